// File: doc/BRIEF.md
# Pipelined Systolic Unsigned Multiplier

The block multiplies two N-bit unsigned integers and returns the full 2N-bit product. It is a regular grid of identical registered cells. Each cell ANDs one bit of each operand to form a partial-product bit and adds it to an incoming sum bit and carry bit. It registers the new sum bit in place and sends the new carry to the next column.

N carry-save rows each fold in one partial-product row. Delay chains at the left edge skew the operand bits so that row k sees multiplier bit k and the multiplicand exactly k cycles after they arrive. Below the rows, a chain of 2N merge cells resolves the carry-save pair one bit position per cycle.

Every stage is one full-adder deep, so a new operand pair can be presented on every clock. A valid bit travels through a delay line of the same depth as the data path.

Top module: `sysmul_top`

## Requirements
- R1: While rst_n is low, and on the first cycle after it returns high, out_valid is 0 and out_prod is 0.
- R2: For an accepted pair, out_prod equals in_a times in_b as a 2N-bit unsigned value with no truncation, including zero operands and all-ones operands.
- R3: in_valid is sampled with the operands on a rising edge. The matching out_valid and out_prod are present after the 3N-th rising edge, counting that sampling edge as the first. A single isolated pair produces exactly one cycle of out_valid.
- R4: Pairs presented on consecutive cycles produce products on consecutive cycles, one per clock, each matching its own pair.
- R5: out_valid repeats the in_valid pattern delayed by 3N cycles. Cycles with in_valid low produce cycles with out_valid low.
- R6: After reset is released, out_valid stays low until the first valid operands have crossed the whole array.
- R7: No carry is lost from the top column of any row or merge cell. All-ones times all-ones gives 2^(2N) - 2^(N+1) + 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair on in_a/in_b is to be multiplied |
| in_a | input | N | Multiplicand, unsigned |
| in_b | input | N | Multiplier, unsigned |
| out_valid | output | 1 | out_prod holds a finished product |
| out_prod | output | 2N | Unsigned product |

## Verification
Two functions can fall in the same clock cycle: the array accepts a new operand pair while it delivers the product of a pair taken 3N cycles earlier. The bench provokes this overlap with a long back-to-back burst, a burst with random bubbles, and a lone pair surrounded by idle cycles. It compares every output cycle's valid bit and product against a queue of its own expected results indexed by the cycle of entry. An isolated pair that is one cycle early or late, or a neighbouring product that leaks into its slot, therefore shows up as a mismatch.

// File: rtl/sysmul_pkg.sv
`timescale 1ns/1ps
package sysmul_pkg;

  typedef struct packed {
    logic s;
    logic c;
  } fa_t;

  // one-bit full adder: parity sum and majority carry
  function automatic fa_t full_add(input logic x, input logic y, input logic z);
    fa_t r;
    r.s = x ^ y ^ z;
    r.c = (x & y) | (x & z) | (y & z);
    return r;
  endfunction

endpackage

// File: rtl/sysmul_cell.sv
`timescale 1ns/1ps
module sysmul_cell
  import sysmul_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic a_bit,
  input  logic b_bit,
  input  logic s_in,
  input  logic c_in,
  output logic s_q,
  output logic c_q
);

  fa_t nxt;

  always_comb nxt = full_add(s_in, c_in, a_bit & b_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q <= 1'b0;
      c_q <= 1'b0;
    end else begin
      s_q <= nxt.s;
      c_q <= nxt.c;
    end
  end

endmodule

// File: rtl/sysmul_delay.sv
`timescale 1ns/1ps
module sysmul_delay #(
  parameter int WIDTH = 1,
  parameter int DEPTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] st [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < DEPTH; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[DEPTH-1];

endmodule

// File: rtl/sysmul_csa_row.sv
`timescale 1ns/1ps
module sysmul_csa_row #(
  parameter int N   = 8,
  parameter int ROW = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   a_in,
  input  logic           b_bit,
  input  logic [2*N-1:0] s_in,
  input  logic [2*N-1:0] c_in,
  output logic [2*N-1:0] s_q,
  output logic [2*N-1:0] c_q,
  output logic           top_carry_q
);

  localparam int W = 2 * N;

  logic [W-1:0] carry_w;

  for (genvar j = 0; j < W; j++) begin : g_col
    if (j >= ROW && j < ROW + N) begin : g_pp
      sysmul_cell u_cell (
        .clk(clk), .rst_n(rst_n),
        .a_bit(a_in[j-ROW]), .b_bit(b_bit),
        .s_in(s_in[j]), .c_in(c_in[j]),
        .s_q(s_q[j]), .c_q(carry_w[j])
      );
    end else begin : g_pass
      sysmul_cell u_cell (
        .clk(clk), .rst_n(rst_n),
        .a_bit(1'b0), .b_bit(1'b0),
        .s_in(s_in[j]), .c_in(c_in[j]),
        .s_q(s_q[j]), .c_q(carry_w[j])
      );
    end
  end

  // carries move one column up; the top column's carry is exposed for checking
  assign c_q         = {carry_w[W-2:0], 1'b0};
  assign top_carry_q = carry_w[W-1];

endmodule

// File: rtl/sysmul_merge_stage.sv
`timescale 1ns/1ps
module sysmul_merge_stage
  import sysmul_pkg::*;
#(
  parameter int W   = 16,
  parameter int POS = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] s_in,
  input  logic [W-1:0] c_in,
  input  logic         cy_in,
  output logic [W-1:0] s_q,
  output logic [W-1:0] c_q,
  output logic         cy_q
);

  fa_t          r;
  logic [W-1:0] s_nxt;
  logic [W-1:0] c_nxt;

  always_comb begin
    r          = full_add(s_in[POS], c_in[POS], cy_in);
    s_nxt      = s_in;
    s_nxt[POS] = r.s;
    c_nxt      = c_in;
    c_nxt[POS] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q  <= '0;
      c_q  <= '0;
      cy_q <= 1'b0;
    end else begin
      s_q  <= s_nxt;
      c_q  <= c_nxt;
      cy_q <= r.c;
    end
  end

endmodule

// File: rtl/sysmul_top.sv
`timescale 1ns/1ps
module sysmul_top #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [N-1:0]   in_a,
  input  logic [N-1:0]   in_b,
  output logic           out_valid,
  output logic [2*N-1:0] out_prod
);

  localparam int W   = 2 * N;
  localparam int LAT = 3 * N;

  // operand skew at the array edge
  logic [N-1:0] a_d [N];
  logic [N-1:0] b_row;

  assign a_d[0]   = in_a;
  assign b_row[0] = in_b[0];

  for (genvar k = 1; k < N; k++) begin : g_skew
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) a_d[k] <= '0;
      else        a_d[k] <= a_d[k-1];
    end
    sysmul_delay #(.WIDTH(1), .DEPTH(k)) u_bdly (
      .clk(clk), .rst_n(rst_n), .d(in_b[k]), .q(b_row[k])
    );
  end

  // carry-save rows
  logic [W-1:0] rs [N+1];
  logic [W-1:0] rc [N+1];
  logic [N-1:0] row_ovf;

  assign rs[0] = '0;
  assign rc[0] = '0;

  for (genvar k = 0; k < N; k++) begin : g_row
    sysmul_csa_row #(.N(N), .ROW(k)) u_row (
      .clk(clk), .rst_n(rst_n),
      .a_in(a_d[k]), .b_bit(b_row[k]),
      .s_in(rs[k]), .c_in(rc[k]),
      .s_q(rs[k+1]), .c_q(rc[k+1]),
      .top_carry_q(row_ovf[k])
    );
  end

  // bit-serial carry merge
  logic [W-1:0] ms  [W+1];
  logic [W-1:0] mc  [W+1];
  logic [W:0]   mcy;
  logic         merge_ovf;
  logic [W-1:0] merge_c_left;

  assign ms[0]  = rs[N];
  assign mc[0]  = rc[N];
  assign mcy[0] = 1'b0;

  for (genvar p = 0; p < W; p++) begin : g_merge
    sysmul_merge_stage #(.W(W), .POS(p)) u_mrg (
      .clk(clk), .rst_n(rst_n),
      .s_in(ms[p]), .c_in(mc[p]), .cy_in(mcy[p]),
      .s_q(ms[p+1]), .c_q(mc[p+1]), .cy_q(mcy[p+1])
    );
  end

  assign merge_ovf    = mcy[W];
  assign merge_c_left = mc[W];
  assign out_prod     = ms[W];

  // valid delay line matching the data path depth
  sysmul_delay #(.WIDTH(1), .DEPTH(LAT)) u_vdly (
    .clk(clk), .rst_n(rst_n), .d(in_valid), .q(out_valid)
  );

endmodule

// File: rtl/sysmul_checker.sv
`timescale 1ns/1ps
module sysmul_checker #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [N-1:0]   in_a,
  input logic [N-1:0]   in_b,
  input logic           out_valid,
  input logic [2*N-1:0] out_prod,
  input logic [N-1:0]   row_ovf,
  input logic           merge_ovf,
  input logic [2*N-1:0] merge_c_left
);

  localparam int W   = 2 * N;
  localparam int LAT = 3 * N;
  localparam int CW  = $clog2(LAT + 1);

  logic           ref_v [LAT];
  logic [W-1:0]   ref_p [LAT];
  logic [CW-1:0]  cyc;
  logic [W-1:0]   prod_now;

  assign prod_now = W'(in_a) * W'(in_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) begin
        ref_v[i] <= 1'b0;
        ref_p[i] <= '0;
      end
      cyc <= '0;
    end else begin
      ref_v[0] <= in_valid;
      ref_p[0] <= prod_now;
      for (int i = 1; i < LAT; i++) begin
        ref_v[i] <= ref_v[i-1];
        ref_p[i] <= ref_p[i-1];
      end
      if (cyc < CW'(LAT)) cyc <= cyc + 1'b1;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_prod == '0));

  assert_product_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_prod == ref_p[LAT-1]);

  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == ref_v[LAT-1]);

  assert_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc < CW'(LAT)) |-> !out_valid);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (row_ovf == '0) && !merge_ovf && (merge_c_left == '0));

endmodule

bind sysmul_top sysmul_checker #(.N(N)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
  .out_valid(out_valid), .out_prod(out_prod), .row_ovf(row_ovf),
  .merge_ovf(merge_ovf), .merge_c_left(merge_c_left)
);

// File: tb/sysmul_top_tb_top.sv
`timescale 1ns/1ps
module sysmul_top_tb_top;

  localparam int N     = 8;
  localparam int W     = 2 * N;
  localparam int LAT   = 3 * N;
  localparam int NSTIM = 300;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [N-1:0] in_a = '0;
  logic [N-1:0] in_b = '0;
  logic         out_valid;
  logic [W-1:0] out_prod;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic         st_v [NSTIM];
  logic [N-1:0] st_a [NSTIM];
  logic [N-1:0] st_b [NSTIM];
  string        st_t [NSTIM];

  always #10 clk = ~clk;

  sysmul_top #(.N(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_prod(out_prod)
  );

  function automatic logic [W-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
    logic [W-1:0] acc = '0;
    for (int i = 0; i < N; i++)
      if (b[i]) acc = acc + (W'(a) << i);
    return acc;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic set_stim(input int i, input logic v, input logic [N-1:0] a,
                          input logic [N-1:0] b, input string t);
    st_v[i] = v; st_a[i] = a; st_b[i] = b; st_t[i] = t;
  endtask

  initial begin
    logic [31:0]  r;
    logic [N-1:0] maxv, alt, one;
    maxv = '1;
    one  = N'(1);
    alt  = '0;
    for (int i = 0; i < N; i += 2) alt[i] = 1'b1;
    r = $urandom(32'd20240611);
    for (int i = 0; i < NSTIM; i++) set_stim(i, 1'b0, '0, '0, "R5");
    set_stim(0, 1'b1, '0, '0, "R2");
    set_stim(1, 1'b1, maxv, maxv, "R7");
    set_stim(2, 1'b1, maxv, one, "R2");
    set_stim(3, 1'b1, one, maxv, "R2");
    set_stim(5, 1'b1, maxv, '0, "R2");
    set_stim(6, 1'b1, alt, ~alt, "R2");
    set_stim(20, 1'b1, 8'hC5, 8'h3B, "R3");
    for (int i = 40; i < 140; i++) begin
      r = $urandom;
      set_stim(i, 1'b1, r[N-1:0], r[2*N-1:N], "R4");
    end
    set_stim(70, 1'b1, maxv, maxv, "R7");
    for (int i = 140; i < NSTIM; i++) begin
      r = $urandom;
      if (r[31]) set_stim(i, 1'b1, r[N-1:0], r[2*N-1:N], "R2");
    end

    // reset behaviour
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", W'(out_valid), '0);
    check("R1 out_prod in reset", out_prod, '0);
    rst_n = 1'b1;

    for (int j = 0; j < NSTIM + LAT + 2; j++) begin
      int k;
      k = j - LAT;
      if (j == 1) check("R1 out_prod after release", out_prod, '0);
      if (k < 0) begin
        check("R6 out_valid during fill", W'(out_valid), '0);
      end else if (k < NSTIM) begin
        check({st_t[k], " out_valid"}, W'(out_valid), W'(st_v[k]));
        if (st_v[k]) check({st_t[k], " out_prod"}, out_prod, ref_mul(st_a[k], st_b[k]));
      end else begin
        check("R5 out_valid idle tail", W'(out_valid), '0);
      end
      if (j < NSTIM) begin
        in_valid = st_v[j]; in_a = st_a[j]; in_b = st_b[j];
      end else begin
        in_valid = 1'b0; in_a = '0; in_b = '0;
      end
      @(negedge clk);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule